// File: doc/BRIEF.md
# Load/Store-Multiple Micro-Op Sequencer

This block turns one multi-register memory transfer into a stream of single-word micro-operations for an in-order pipeline with four stages: Issue, Execute, Memory and Writeback. A start pulse brings in a register bitmask, a base byte address and a direction flag (load or store). From the next cycle on, the block places one micro-op into Issue every cycle. Each micro-op carries a register index, a word address and first/last markers. The block then tracks every micro-op as it moves down through Execute, Memory and Writeback.

The micro-ops overlap, one stage apart. Issue stays occupied for as many cycles as there are set bits in the mask, so an N-word transfer spans N+3 cycles from the first issue to the last writeback. A two-word transfer, including a double-word access expressed as a two-bit mask, holds Issue for two back-to-back cycles. Each load's data becomes available at Memory. Dependent instructions are released only by the final load micro-op, which is flagged at the Memory stage. Each store micro-op presents its own source register at Memory. A saturated word count is also published for the scheduling logic.

Top module: `lsm_seq`

## Requirements
- R1: After reset, busy_o, uop_valid_o, mem_valid_o, done_o, final_load_o and stage_busy_o are all 0.
- R2: Micro-ops visit the set bits of the mask in ascending register index, and the k-th micro-op (k from 0) carries address base + 4k.
- R3: uop_first_o is 1 only on the first micro-op of a transfer and uop_last_o only on the last; a one-word transfer has both on its single micro-op.
- R4: An accepted start with N set bits yields micro-ops in the N consecutive cycles that follow the accepting edge, one per cycle, and busy_o is 1 in exactly those cycles.
- R5: A micro-op in Issue in cycle t is at Memory in cycle t+2 (mem_valid_o, mem_reg_o, mem_addr_o) and at Writeback in cycle t+3; stage_busy_o bits 0..3 show Issue, Execute, Memory and Writeback occupancy, and all four bits are 1 together for max(N-3,0) cycles.
- R6: For a load transfer, final_load_o is 1 for exactly one cycle, when the last micro-op is at Memory; for a store it stays 0.
- R7: At Memory, mem_load_o equals the direction of the transfer (1 load, 0 store), so each store micro-op presents its own register index there.
- R8: done_o pulses for one cycle when the last micro-op is at Writeback; an empty mask issues nothing, keeps busy_o at 0 and pulses done_o in the cycle after the accepting edge.
- R9: A start arriving while busy_o is 1 is ignored: the running sequence continues unchanged and no new one follows.
- R10: From the cycle after an accepting edge, issue_slots_o equals the number of set bits in the mask, capped at 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse; accepted only while busy_o is 0 |
| mask_i | input | 16 | Register list, bit i selects register i |
| base_i | input | 32 | Byte address of the first word |
| is_load_i | input | 1 | 1 for load, 0 for store |
| busy_o | output | 1 | Issue held by the running transfer |
| uop_valid_o | output | 1 | Micro-op present in Issue |
| uop_reg_o | output | 4 | Register index of the Issue micro-op |
| uop_addr_o | output | 32 | Word address of the Issue micro-op |
| uop_first_o | output | 1 | First micro-op of the transfer |
| uop_last_o | output | 1 | Last micro-op of the transfer |
| mem_valid_o | output | 1 | Micro-op present in Memory |
| mem_reg_o | output | 4 | Register index at Memory |
| mem_addr_o | output | 32 | Address at Memory |
| mem_load_o | output | 1 | Direction of the micro-op at Memory |
| final_load_o | output | 1 | Last load's data ready at Memory |
| done_o | output | 1 | Transfer retired |
| stage_busy_o | output | 4 | Occupancy of Issue, Execute, Memory, Writeback |
| issue_slots_o | output | 4 | Word count capped at 8 |

## Verification
A corrupted remaining-mask register shows on uop_reg_o in the very next Issue cycle, as a skipped or repeated index. It also shows as busy_o staying high too long or dropping too early. A wrong address counter is visible on the next micro-op's address. A slip in the stage chain shows two cycles later at Memory, where mem_reg_o, final_load_o and the all-stages-busy count no longer match the issue order. A broken start guard shows at once as a reloaded issue_slots_o or a changed sequence in mid-transfer.

// File: rtl/lsm_pkg.sv
package lsm_pkg;

    localparam int LSM_NREG   = 16;
    localparam int LSM_AW     = 32;
    localparam int LSM_REG_W  = $clog2(LSM_NREG);
    localparam int LSM_CNT_W  = $clog2(LSM_NREG + 1);
    localparam int LSM_SLOT_W = 4;

    typedef struct packed {
        logic                 vld;
        logic                 load;
        logic                 first;
        logic                 last;
        logic [LSM_REG_W-1:0] rid;
        logic [LSM_AW-1:0]    addr;
    } uop_t;

    // index of the lowest set bit (0 if none)
    function automatic logic [LSM_REG_W-1:0] lowest_idx(input logic [LSM_NREG-1:0] m);
        logic [LSM_REG_W-1:0] r;
        r = '0;
        for (int i = LSM_NREG - 1; i >= 0; i--) begin
            if (m[i]) r = LSM_REG_W'(i);
        end
        return r;
    endfunction

    function automatic logic [LSM_CNT_W-1:0] pop_cnt(input logic [LSM_NREG-1:0] m);
        logic [LSM_CNT_W-1:0] c;
        c = '0;
        for (int i = 0; i < LSM_NREG; i++) c = c + LSM_CNT_W'(m[i]);
        return c;
    endfunction

    function automatic logic [LSM_SLOT_W-1:0] cap_cnt(input logic [LSM_CNT_W-1:0] c,
                                                     input int lim);
        if (int'(c) > lim) return LSM_SLOT_W'(lim);
        return LSM_SLOT_W'(c);
    endfunction

endpackage

// File: rtl/lsm_pick.sv
module lsm_pick
    import lsm_pkg::*;
(
    input  logic [LSM_NREG-1:0]  mask_i,
    output logic [LSM_REG_W-1:0] idx_o,
    output logic                 any_o,
    output logic                 single_o,
    output logic [LSM_NREG-1:0]  rest_o
);
    logic [LSM_NREG-1:0] minus_one;

    always_comb begin
        minus_one = mask_i - LSM_NREG'(1);
        rest_o    = mask_i & minus_one;
        any_o     = |mask_i;
        single_o  = any_o && (rest_o == '0);
        idx_o     = lowest_idx(mask_i);
    end
endmodule

// File: rtl/lsm_stage_pipe.sv
module lsm_stage_pipe
    import lsm_pkg::*;
#(
    parameter int DEPTH  = 3,
    parameter int MM_POS = 1
) (
    input  logic clk,
    input  logic rst,
    input  uop_t issue_i,
    output uop_t stg_o [DEPTH],
    output logic final_load_o
);
    uop_t stg_q [DEPTH];

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_stage
            if (g == 0) begin : g_head
                always_ff @(posedge clk) begin
                    if (rst) stg_q[g] <= '0;
                    else     stg_q[g] <= issue_i;
                end
            end else begin : g_tail
                always_ff @(posedge clk) begin
                    if (rst) stg_q[g] <= '0;
                    else     stg_q[g] <= stg_q[g-1];
                end
            end
            assign stg_o[g] = stg_q[g];
        end
    endgenerate

    assign final_load_o = stg_q[MM_POS].vld && stg_q[MM_POS].load && stg_q[MM_POS].last;

    AST_FINAL_SINGLE: assert property (@(posedge clk) disable iff (rst)
        final_load_o |=> !final_load_o); // R6

    AST_LAST_DRAINS: assert property (@(posedge clk) disable iff (rst)
        (issue_i.vld && issue_i.last) |=> !issue_i.vld); // R3
endmodule

// File: rtl/lsm_seq.sv
module lsm_seq
    import lsm_pkg::*;
#(
    parameter int SAT_LIMIT  = 8,
    parameter int WORD_BYTES = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start_i,
    input  logic [LSM_NREG-1:0]   mask_i,
    input  logic [LSM_AW-1:0]     base_i,
    input  logic                  is_load_i,
    output logic                  busy_o,
    output logic                  uop_valid_o,
    output logic [LSM_REG_W-1:0]  uop_reg_o,
    output logic [LSM_AW-1:0]     uop_addr_o,
    output logic                  uop_first_o,
    output logic                  uop_last_o,
    output logic                  mem_valid_o,
    output logic [LSM_REG_W-1:0]  mem_reg_o,
    output logic [LSM_AW-1:0]     mem_addr_o,
    output logic                  mem_load_o,
    output logic                  final_load_o,
    output logic                  done_o,
    output logic [3:0]            stage_busy_o,
    output logic [LSM_SLOT_W-1:0] issue_slots_o
);
    localparam int POST_STAGES = 3;
    localparam int EX_POS      = 0;
    localparam int MM_POS      = 1;
    localparam int WB_POS      = 2;

    logic [LSM_NREG-1:0]   rem_q;
    logic [LSM_AW-1:0]     addr_q;
    logic                  first_q;
    logic                  load_q;
    logic                  empty_q;
    logic [LSM_SLOT_W-1:0] slots_q;

    logic [LSM_REG_W-1:0]  pick_idx;
    logic                  pick_any;
    logic                  pick_single;
    logic [LSM_NREG-1:0]   pick_rest;
    logic                  accept;
    uop_t                  issue_uop;
    uop_t                  stg [POST_STAGES];

    lsm_pick u_pick (
        .mask_i   (rem_q),
        .idx_o    (pick_idx),
        .any_o    (pick_any),
        .single_o (pick_single),
        .rest_o   (pick_rest)
    );

    assign accept = start_i && !pick_any;

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q   <= '0;
            addr_q  <= '0;
            first_q <= 1'b0;
            load_q  <= 1'b0;
            empty_q <= 1'b0;
            slots_q <= '0;
        end else begin
            empty_q <= accept && (mask_i == '0);
            if (accept) begin
                rem_q   <= mask_i;
                addr_q  <= base_i;
                first_q <= 1'b1;
                load_q  <= is_load_i;
                slots_q <= cap_cnt(pop_cnt(mask_i), SAT_LIMIT);
            end else if (pick_any) begin
                rem_q   <= pick_rest;
                addr_q  <= addr_q + LSM_AW'(WORD_BYTES);
                first_q <= 1'b0;
            end
        end
    end

    always_comb begin
        issue_uop.vld   = pick_any;
        issue_uop.load  = load_q;
        issue_uop.first = first_q;
        issue_uop.last  = pick_single;
        issue_uop.rid   = pick_idx;
        issue_uop.addr  = addr_q;
    end

    lsm_stage_pipe #(
        .DEPTH  (POST_STAGES),
        .MM_POS (MM_POS)
    ) u_pipe (
        .clk          (clk),
        .rst          (rst),
        .issue_i      (issue_uop),
        .stg_o        (stg),
        .final_load_o (final_load_o)
    );

    assign busy_o        = pick_any;
    assign uop_valid_o   = issue_uop.vld;
    assign uop_reg_o     = issue_uop.rid;
    assign uop_addr_o    = issue_uop.addr;
    assign uop_first_o   = issue_uop.vld && issue_uop.first;
    assign uop_last_o    = issue_uop.vld && issue_uop.last;
    assign mem_valid_o   = stg[MM_POS].vld;
    assign mem_reg_o     = stg[MM_POS].rid;
    assign mem_addr_o    = stg[MM_POS].addr;
    assign mem_load_o    = stg[MM_POS].load;
    assign done_o        = (stg[WB_POS].vld && stg[WB_POS].last) || empty_q;
    assign stage_busy_o  = {stg[WB_POS].vld, stg[MM_POS].vld, stg[EX_POS].vld, issue_uop.vld};
    assign issue_slots_o = slots_q;

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        (uop_valid_o && !uop_last_o) |=> (uop_addr_o == $past(uop_addr_o) + LSM_AW'(WORD_BYTES))); // R2

    AST_REG_ASCEND: assert property (@(posedge clk) disable iff (rst)
        (uop_valid_o && !uop_last_o) |=> (uop_reg_o > $past(uop_reg_o))); // R2

    AST_ONE_PER_CYCLE: assert property (@(posedge clk) disable iff (rst)
        busy_o |=> ($countones(rem_q) == $countones($past(rem_q)) - 1)); // R4

    AST_FIRST_AFTER_IDLE: assert property (@(posedge clk) disable iff (rst)
        (uop_valid_o && !$past(busy_o)) |-> uop_first_o); // R3

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        busy_o |=> $stable(issue_slots_o)); // R9

    AST_SLOTS_CAP: assert property (@(posedge clk) disable iff (rst)
        int'(issue_slots_o) <= SAT_LIMIT); // R10
endmodule

// File: tb/lsm_seq_tb.sv
module lsm_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [15:0] mask_i = '0;
    logic [31:0] base_i = '0;
    logic        is_load_i = 1'b0;
    logic        busy_o, uop_valid_o, uop_first_o, uop_last_o;
    logic [3:0]  uop_reg_o, mem_reg_o, stage_busy_o, issue_slots_o;
    logic [31:0] uop_addr_o, mem_addr_o;
    logic        mem_valid_o, mem_load_o, final_load_o, done_o;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    lsm_seq dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .mask_i(mask_i), .base_i(base_i),
        .is_load_i(is_load_i), .busy_o(busy_o), .uop_valid_o(uop_valid_o),
        .uop_reg_o(uop_reg_o), .uop_addr_o(uop_addr_o), .uop_first_o(uop_first_o),
        .uop_last_o(uop_last_o), .mem_valid_o(mem_valid_o), .mem_reg_o(mem_reg_o),
        .mem_addr_o(mem_addr_o), .mem_load_o(mem_load_o), .final_load_o(final_load_o),
        .done_o(done_o), .stage_busy_o(stage_busy_o), .issue_slots_o(issue_slots_o)
    );

    task automatic chk(input logic ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // one transfer: start, then watch every cycle until well after retirement
    task automatic run_seq(input logic [15:0] m, input logic [31:0] b, input logic ld,
                           input logic inject);
        int er[16];
        int n = 0;
        int full = 0;
        int exp_full;
        for (int i = 0; i < 16; i++) if (m[i]) begin er[n] = i; n++; end
        exp_full = (n > 3) ? n - 3 : 0;
        @(negedge clk);
        start_i = 1'b1; mask_i = m; base_i = b; is_load_i = ld;
        @(negedge clk);
        start_i = 1'b0;
        for (int c = 0; c < n + 5; c++) begin
            chk(busy_o == (c < n), "R4 busy", busy_o, c < n);
            if (c < n) begin
                chk(uop_valid_o, "R4 valid", uop_valid_o, 1);
                chk(uop_reg_o == 4'(er[c]), "R2 reg", uop_reg_o, er[c]);
                chk(uop_addr_o == b + 32'(4 * c), "R2 addr", uop_addr_o, b + 32'(4 * c));
                chk(uop_first_o == (c == 0), "R3 first", uop_first_o, c == 0);
                chk(uop_last_o == (c == n - 1), "R3 last", uop_last_o, c == n - 1);
            end else begin
                chk(!uop_valid_o, "R4 idle", uop_valid_o, 0);
            end
            if (c >= 2 && c - 2 < n) begin
                chk(mem_valid_o, "R5 mem valid", mem_valid_o, 1);
                chk(mem_reg_o == 4'(er[c-2]), "R5 mem reg", mem_reg_o, er[c-2]);
                chk(mem_addr_o == b + 32'(4 * (c - 2)), "R5 mem addr", mem_addr_o, b + 32'(4 * (c - 2)));
                chk(mem_load_o == ld, "R7 mem dir", mem_load_o, ld);
            end else begin
                chk(!mem_valid_o, "R5 mem idle", mem_valid_o, 0);
            end
            chk(final_load_o == (ld && n > 0 && c == n + 1), "R6 final", final_load_o,
                ld && n > 0 && c == n + 1);
            chk(done_o == ((n == 0) ? (c == 0) : (c == n + 2)), "R8 done", done_o,
                (n == 0) ? (c == 0) : (c == n + 2));
            if (c == 0) begin
                int cap = (n > 8) ? 8 : n;
                chk(issue_slots_o == 4'(cap), "R10 slots", issue_slots_o, cap);
            end
            if (stage_busy_o == 4'hF) full++;
            if (inject && c == 2) begin
                start_i = 1'b1; mask_i = 16'h0F0F; base_i = 32'h5000; is_load_i = ~ld;
            end
            if (inject && c == 3) start_i = 1'b0;
            @(negedge clk);
        end
        chk(full == exp_full, "R5 all stages", full, exp_full);
        if (inject) chk(!busy_o && !uop_valid_o, "R9 no restart", busy_o, 0);
    endtask

    task automatic test_reset;
        chk(!busy_o && !uop_valid_o && !mem_valid_o, "R1 idle", busy_o, 0);
        chk(!done_o && !final_load_o, "R1 pulses", done_o, 0);
        chk(stage_busy_o == 4'h0, "R1 stages", stage_busy_o, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        test_reset();
        run_seq(16'h0001, 32'h1000, 1'b1, 1'b0);   // single word
        run_seq(16'h8001, 32'h2000, 1'b0, 1'b0);   // two words, store
        run_seq(16'h00F0, 32'h3000, 1'b1, 1'b0);   // four loads
        run_seq(16'h01A5, 32'h4000, 1'b0, 1'b1);   // store, start while busy (R9)
        run_seq(16'h0000, 32'h6000, 1'b1, 1'b0);   // empty mask (R8)
        run_seq(16'hFFFF, 32'h7000, 1'b1, 1'b0);   // full mask, slots cap (R10)
        run_seq(16'h0300, 32'h8000, 1'b1, 1'b0);   // double word as two bits
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule